// File: doc/BRIEF.md
# Micro-Op Latency and Stall Controller

This block sits beside the issue stage of a simple in-order micro-op pipeline. Each micro-op is offered with a three-bit class code and an operand-width bit. Once accepted, the micro-op holds the issue stage for a number of cycles that depends on its class. The block raises `stall` for every cycle after the accepting cycle except the last. For a control transfer it pulses `flush` so that prefetched work is discarded. For micro-ops that use the external bus it steps a bus phase indicator.

The cost of a push depends on history. A push that follows another push or a memory write must wait for the bus and costs five cycles. A push that follows anything else is absorbed in one cycle. The block keeps the class of the last accepted micro-op so that it can make this choice. The upstream stage keeps `issue_valid` and the micro-op fields stable until `stall` is low. The block ignores any offer that arrives while it stalls.

Top module: `uop_stall_ctrl`

## Requirements
- R1: During and right after a synchronous active-high reset, `stall` and `flush` are 0 and `bus_phase` is Idle (0). The push history is cleared, so the first push after reset costs 1 cycle.
- R2: An accepted ALU (code 0), memory write (code 2) or reserved (codes 6, 7) micro-op costs 1 cycle: `stall` stays low in the next cycle.
- R3: An accepted memory read (code 1) costs 6 cycles: `stall` is high for the 5 cycles that follow acceptance.
- R4: An accepted push (code 3) costs 1 cycle when the micro-op accepted before it was neither a push nor a memory write.
- R5: An accepted push costs 5 cycles when the micro-op accepted before it was a push or a memory write.
- R6: An accepted multiply/divide (code 4) costs 8 cycles with `issue_wide`=0 and 16 cycles with `issue_wide`=1.
- R7: An accepted unconditional fetch (code 5) costs 9 cycles. `flush` is high for exactly the one cycle after acceptance.
- R8: `bus_phase` uses Idle=0, T0=1, T1=2, T2=3, T3=4. For a read it shows Idle and then T0, T1, T2, T3 over the 5 stall cycles. For a 5-cycle push it shows T0 to T3 over its 4 stall cycles. At all other times it is Idle.
- R9: An `issue_valid` seen while `stall` is high is ignored. It changes neither the stall count nor the push history.
- R10: A micro-op is accepted at a clock edge where `issue_valid` is high and `stall` is low. It may be offered in the first cycle that `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A micro-op is offered |
| issue_cls | input | 3 | Class code of the offered micro-op |
| issue_wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| stall | output | 1 | Issue stage must hold |
| flush | output | 1 | One-cycle discard pulse for a control transfer |
| bus_phase | output | 3 | Bus phase indicator |

## Verification
The hardest case to reach is the history dependence of the push cost. A five-cycle push needs a push or a memory write accepted directly before it. An offer ignored during a stall must not count as history. The stimulus builds chains of pushes, writes mixed with pushes, and reads whose stall cycles are flooded with push offers, each followed by a push. A behavioural model predicts the cost and the phase sequence, and the bench compares against it on every clock.

// File: rtl/uop_lat_pkg.sv
package uop_lat_pkg;

    localparam int HOLD_W = 5;

    typedef enum logic [2:0] {
        UC_ALU    = 3'd0,
        UC_MRD    = 3'd1,
        UC_MWR    = 3'd2,
        UC_PUSH   = 3'd3,
        UC_MULDIV = 3'd4,
        UC_UFETCH = 3'd5,
        UC_RSV6   = 3'd6,
        UC_RSV7   = 3'd7
    } uop_cls_e;

    typedef enum logic [2:0] {
        BP_IDLE = 3'd0,
        BP_T0   = 3'd1,
        BP_T1   = 3'd2,
        BP_T2   = 3'd3,
        BP_T3   = 3'd4
    } bus_ph_e;

    typedef struct packed {
        logic [HOLD_W-1:0] hold;     // stall cycles after acceptance
        logic              bus_use;  // runs T0..T3 at the end of the hold
        logic              flush;    // discards prefetched work
    } uop_plan_t;

    // a class after which a push must wait for the bus
    function automatic logic leaves_bus_busy(uop_cls_e c);
        return (c == UC_PUSH) || (c == UC_MWR);
    endfunction

    // phase for a bus-using micro-op with 'rem' stall cycles left
    function automatic bus_ph_e phase_at(logic [HOLD_W-1:0] rem);
        if (rem >= HOLD_W'(1) && rem <= HOLD_W'(4))
            return bus_ph_e'(3'(5 - int'(rem)));
        return BP_IDLE;
    endfunction

endpackage

// File: rtl/uop_plan_calc.sv
module uop_plan_calc
    import uop_lat_pkg::*;
#(
    parameter int LAT_MRD    = 6,
    parameter int LAT_PSLOW  = 5,
    parameter int LAT_MD8    = 8,
    parameter int LAT_MD16   = 16,
    parameter int LAT_UFETCH = 9
) (
    input  uop_cls_e  cls,
    input  logic      wide,
    input  logic      prev_busy,
    output uop_plan_t plan
);
    localparam logic [HOLD_W-1:0] H_MRD   = HOLD_W'(LAT_MRD - 1);
    localparam logic [HOLD_W-1:0] H_PSLOW = HOLD_W'(LAT_PSLOW - 1);
    localparam logic [HOLD_W-1:0] H_MD8   = HOLD_W'(LAT_MD8 - 1);
    localparam logic [HOLD_W-1:0] H_MD16  = HOLD_W'(LAT_MD16 - 1);
    localparam logic [HOLD_W-1:0] H_UF    = HOLD_W'(LAT_UFETCH - 1);

    always_comb begin
        plan = '0;
        unique case (cls)
            UC_MRD: begin
                plan.hold    = H_MRD;
                plan.bus_use = 1'b1;
            end
            UC_PUSH: begin
                if (prev_busy) begin
                    plan.hold    = H_PSLOW;
                    plan.bus_use = 1'b1;
                end
            end
            UC_MULDIV: plan.hold = wide ? H_MD16 : H_MD8;
            UC_UFETCH: begin
                plan.hold  = H_UF;
                plan.flush = 1'b1;
            end
            default: plan = '0;
        endcase
    end
endmodule

// File: rtl/uop_history.sv
module uop_history
    import uop_lat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  uop_cls_e cls,
    output logic     prev_busy
);
    uop_cls_e last_cls;

    always_ff @(posedge clk) begin
        if (rst)         last_cls <= UC_ALU;
        else if (accept) last_cls <= cls;
    end

    assign prev_busy = leaves_bus_busy(last_cls);

    // R9: the record moves only on an accepted micro-op
    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(last_cls));
endmodule

// File: rtl/uop_hold_ctr.sv
module uop_hold_ctr
    import uop_lat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              stall,
    output logic [HOLD_W-1:0] remain
);
    always_ff @(posedge clk) begin
        if (rst)                   remain <= '0;
        else if (load)             remain <= load_val;
        else if (remain != '0)     remain <= remain - 1'b1;
    end

    assign stall = (remain != '0);

    // R10: a hold counts down one per cycle, offers cannot reload it
    assert_countdown_R10: assert property (@(posedge clk) disable iff (rst)
        (remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/uop_bus_seq.sv
module uop_bus_seq
    import uop_lat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              bus_use,
    input  logic [HOLD_W-1:0] remain,
    output bus_ph_e           phase
);
    logic bus_act;

    always_ff @(posedge clk) begin
        if (rst)       bus_act <= 1'b0;
        else if (load) bus_act <= bus_use;
    end

    assign phase = bus_act ? phase_at(remain) : BP_IDLE;

    assert_t0_to_t1_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == BP_T0) |=> (phase == BP_T1));
    assert_t3_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == BP_T3) |=> (phase == BP_IDLE));
    assert_phase_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != BP_IDLE) |-> (remain != '0));
endmodule

// File: rtl/uop_stall_ctrl.sv
module uop_stall_ctrl
    import uop_lat_pkg::*;
#(
    parameter int LAT_MRD    = 6,
    parameter int LAT_PSLOW  = 5,
    parameter int LAT_MD8    = 8,
    parameter int LAT_MD16   = 16,
    parameter int LAT_UFETCH = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_valid,
    input  logic [2:0] issue_cls,
    input  logic       issue_wide,
    output logic       stall,
    output logic       flush,
    output logic [2:0] bus_phase
);
    uop_cls_e          cls;
    logic              accept;
    logic              prev_busy;
    uop_plan_t         plan;
    logic [HOLD_W-1:0] remain;
    bus_ph_e           phase;

    assign cls    = uop_cls_e'(issue_cls);
    assign accept = issue_valid && !stall;

    uop_history u_hist (
        .clk(clk), .rst(rst), .accept(accept), .cls(cls), .prev_busy(prev_busy)
    );

    uop_plan_calc #(
        .LAT_MRD(LAT_MRD), .LAT_PSLOW(LAT_PSLOW), .LAT_MD8(LAT_MD8),
        .LAT_MD16(LAT_MD16), .LAT_UFETCH(LAT_UFETCH)
    ) u_calc (
        .cls(cls), .wide(issue_wide), .prev_busy(prev_busy), .plan(plan)
    );

    uop_hold_ctr u_ctr (
        .clk(clk), .rst(rst), .load(accept), .load_val(plan.hold),
        .stall(stall), .remain(remain)
    );

    uop_bus_seq u_bus (
        .clk(clk), .rst(rst), .load(accept), .bus_use(plan.bus_use),
        .remain(remain), .phase(phase)
    );

    always_ff @(posedge clk) begin
        if (rst) flush <= 1'b0;
        else     flush <= accept && plan.flush;
    end

    assign bus_phase = phase;

    assert_alu_single_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == UC_ALU) |=> !stall);
    assert_read_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == UC_MRD) |=> stall);
    assert_push_fast_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == UC_PUSH && !prev_busy) |=> !stall);
    assert_push_slow_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == UC_PUSH && prev_busy) |=> (stall && bus_phase == 3'd1));
    assert_muldiv_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == UC_MULDIV) |=> stall);
    assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);
    assert_flush_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == UC_UFETCH) |=> (flush && stall));
endmodule

// File: tb/test_uop_stall_ctrl.sv
module test_uop_stall_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue_valid = 1'b0;
    logic [2:0] issue_cls = 3'd0;
    logic       issue_wide = 1'b0;
    logic       stall, flush;
    logic [2:0] bus_phase;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    uop_stall_ctrl i_uop_stall_ctrl (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_cls(issue_cls),
        .issue_wide(issue_wide), .stall(stall), .flush(flush), .bus_phase(bus_phase)
    );

    // ---------------- behavioural reference ----------------
    int    m_rem = 0;
    int    m_q[$];
    bit    m_flush = 0;
    int    m_last = 0;
    bit    m_ign = 0;
    string m_tag = "R2";

    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0; m_q.delete(); m_flush = 0; m_last = 0; m_tag = "R1"; m_ign = 0;
        end else begin
            m_flush = 0;
            m_ign = 0;
            if (m_rem > 0) begin
                if (issue_valid) m_ign = 1;
                m_rem = m_rem - 1;
                if (m_q.size() > 0) void'(m_q.pop_front());
            end else if (issue_valid) begin
                int lat;
                lat = 1; m_tag = "R2"; m_q.delete();
                case (issue_cls)
                    3'd1: begin lat = 6; m_tag = "R3"; m_q = '{0, 1, 2, 3, 4}; end
                    3'd3: if (m_last == 3 || m_last == 2) begin
                              lat = 5; m_tag = "R5"; m_q = '{1, 2, 3, 4};
                          end else m_tag = "R4";
                    3'd4: begin lat = issue_wide ? 16 : 8; m_tag = "R6"; end
                    3'd5: begin lat = 9; m_tag = "R7"; m_flush = 1; end
                    default: ;
                endcase
                m_last = issue_cls;
                m_rem = lat - 1;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                chk("R1", "stall in reset", stall, 0);
                chk("R1", "flush in reset", flush, 0);
                chk("R1", "phase in reset", bus_phase, 0);
            end else begin
                chk(m_ign ? "R9" : m_tag, "stall (R10)", stall, m_rem > 0);
                chk("R7", "flush", flush, m_flush);
                chk("R8", "bus_phase", bus_phase, m_q.size() > 0 ? m_q[0] : 0);
            end
        end
    end

    // ---------------- stimulus ----------------
    // offer one micro-op; while stalled, optionally flood with push offers
    task automatic issue(int c, bit w, bit junk);
        @(negedge clk);
        while (stall) begin
            issue_valid = junk; issue_cls = 3'd3; issue_wide = 1'b1;
            @(negedge clk);
        end
        issue_valid = 1'b1; issue_cls = 3'(c); issue_wide = w;
        @(negedge clk);
        issue_valid = 1'b0; issue_cls = 3'd0;
    endtask

    task automatic gap(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        gap(3);
        @(negedge clk); rst = 1'b0;
        issue(3, 0, 0);      // R1/R4: first push after reset is cheap
        issue(3, 0, 0);      // R5: push after push
        issue(3, 0, 0);      // R5: chain
        issue(0, 0, 0);      // R2
        issue(3, 0, 0);      // R4: push after ALU
        issue(2, 0, 0);      // R2: write
        issue(3, 0, 0);      // R5: push after write
        gap(2);
        issue(1, 0, 0);      // R3/R8
        issue(3, 0, 0);      // R4: push after read
        issue(1, 1, 1);      // R9: flood read with push offers
        issue(3, 0, 0);      // R4: history untouched by ignored offers
        issue(4, 0, 1);      // R6 8-bit
        issue(4, 1, 0);      // R6 16-bit
        issue(5, 0, 1);      // R7
        issue(5, 1, 0);      // R7 back to back
        issue(6, 0, 0);      // R2 reserved
        issue(7, 1, 0);      // R2 reserved
        issue(2, 0, 0);
        issue(2, 0, 0);
        issue(3, 1, 0);      // R5
        issue(1, 0, 0);      // R3 right after slow push (R10)
        issue(3, 0, 0);
        gap(3);
        rst = 1'b1;          // R1: history cleared by reset
        issue(3, 0, 0);
        gap(2);
        @(negedge clk); rst = 1'b0;
        issue(2, 0, 0);
        rst = 1'b1; gap(2); rst = 1'b0;
        issue(3, 0, 0);      // R1: cheap despite write before reset
        gap(6);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule